// File: doc/BRIEF.md
# Memory Address Region Translator

The translator sits in front of two memory controllers and turns raw request addresses into controller-local addresses. Three base registers divide the address space into tiers. A processor request below the real-packet base is steered toward the control-memory bus, and any other processor request is steered toward the packet-memory bus. The address passes through unchanged, because bus arbitration happens outside this block. Requests that arrive on the control-memory bus are rebased against the control base. Requests that arrive on the packet-memory bus fall into two groups. Those below the virtual base are rebased against the real-packet base. Those at or above the virtual base are treated as virtual buffer addresses.

A virtual address is first turned into an offset from the virtual base. The bits of that offset above the buffer length select one entry of a small real-buffer map. The entry gives the real start address of that buffer, and the low offset bits are added to it. If the index falls beyond the map, the request is consumed and an error pulse is raised instead of a forward.

All ports use valid/ready handshakes. Each output is registered, so a translated address appears one clock after the request is accepted. A flat register port writes and reads the three bases and the map entries.

Top module: `mem_region_xlat`

## Requirements
- R1: After reset every output valid and the error flag are low. The control base reads 0, the real-packet base reads RPK_BASE_RST (default 0x0010_0000), the virtual base reads 0x0040_0000 and every map entry reads 0.
- R2: A processor request whose address is below the real-packet base appears on the control-bus-side output. Any other processor request appears on the packet-bus-side output. In both cases the address is unchanged and appears one cycle after acceptance.
- R3: A control-bus request is forwarded to the control-memory output with address = request address minus the control base, modulo 2^ADDR_W.
- R4: A packet-bus request below the virtual base is forwarded with address = request address minus the real-packet base.
- R5: A packet-bus request at or above the virtual base is forwarded with address = map[idx] + (off mod 2^BUF_LOG2). Here off = address minus the virtual base, and idx = off >> BUF_LOG2.
- R6: A virtual request with idx >= MAP_DEPTH is accepted and not forwarded. pmem_err_o is high for one cycle, in the cycle after acceptance.
- R7: Bits VM_LSB-1:0 (default 16:0) of the virtual base ignore writes and always read as zero.
- R8: While an output is valid and its ready input is low, the output keeps its valid and address, and the feeding input's ready is low.
- R9: Register select works as follows. With cfg_addr_i MSB = 0, the low bits choose 0 = control base, 1 = real-packet base, 2 = virtual base; any other code reads 0 and ignores writes. With MSB = 1, the low log2(MAP_DEPTH) bits choose a map entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | CFG_AW | Register select (see R9) |
| cfg_wdata_i | input | ADDR_W | Register write data |
| cfg_rdata_o | output | ADDR_W | Register read data for cfg_addr_i |
| cpu_valid_i | input | 1 | Processor request valid |
| cpu_ready_o | output | 1 | Processor request accepted |
| cpu_addr_i | input | ADDR_W | Processor request address |
| cpu_cbus_valid_o | output | 1 | Routed processor request toward the control bus |
| cpu_cbus_ready_i | input | 1 | Control-bus side ready |
| cpu_cbus_addr_o | output | ADDR_W | Routed address |
| cpu_pbus_valid_o | output | 1 | Routed processor request toward the packet bus |
| cpu_pbus_ready_i | input | 1 | Packet-bus side ready |
| cpu_pbus_addr_o | output | ADDR_W | Routed address |
| cbus_valid_i | input | 1 | Control-bus request valid |
| cbus_ready_o | output | 1 | Control-bus request accepted |
| cbus_addr_i | input | ADDR_W | Control-bus request address |
| cmem_valid_o | output | 1 | Control-memory request valid |
| cmem_ready_i | input | 1 | Control-memory ready |
| cmem_addr_o | output | ADDR_W | Rebased control address |
| pbus_valid_i | input | 1 | Packet-bus request valid |
| pbus_ready_o | output | 1 | Packet-bus request accepted |
| pbus_addr_i | input | ADDR_W | Packet-bus request address |
| pmem_valid_o | output | 1 | Packet-memory request valid |
| pmem_ready_i | input | 1 | Packet-memory ready |
| pmem_addr_o | output | ADDR_W | Real packet address |
| pmem_err_o | output | 1 | Virtual index beyond map (one-cycle pulse) |

## Verification
The bench builds the block with a 64-byte buffer length and a four-entry map, and keeps the address width at 32 bits and the virtual base granularity at 128 KB. With these values, a sweep of a few hundred packet-bus addresses on either side of the virtual base visits every map entry and every buffer seam. The same sweep crosses the exact index where the map ends, so the error path is reached with few stimuli. Separate dense sweeps across the real-packet and control boundaries check the routing comparison and the subtractions arithmetically.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned SEL_CTL = 0;
  localparam int unsigned SEL_RPK = 1;
  localparam int unsigned SEL_VM  = 2;
endpackage

// File: rtl/xlat_slice.sv
module xlat_slice #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready_o  = !v_q || out_ready_i;
  assign out_valid_o = v_q;
  assign out_data_o  = d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_ready_o) begin
      v_q <= in_valid_i;
      if (in_valid_i) d_q <= in_data_i;
    end
  end
endmodule

// File: rtl/xlat_cfg.sv
module xlat_cfg #(
  parameter int                ADDR_W      = 32,
  parameter int                MAP_DEPTH   = 16,
  parameter int                VM_LSB      = 17,
  parameter logic [ADDR_W-1:0] RPK_BASE_RST = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] VM_BASE_RST  = 32'h0040_0000,
  localparam int MAP_IDX_W = $clog2(MAP_DEPTH),
  localparam int CFG_AW    = ((MAP_IDX_W > 2) ? MAP_IDX_W : 2) + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CFG_AW-1:0]                addr_i,
  input  logic [ADDR_W-1:0]                wdata_i,
  output logic [ADDR_W-1:0]                rdata_o,
  output logic [ADDR_W-1:0]                ctl_base_o,
  output logic [ADDR_W-1:0]                rpk_base_o,
  output logic [ADDR_W-1:0]                vm_base_o,
  output logic [MAP_DEPTH-1:0][ADDR_W-1:0] map_o
);
  import xlat_pkg::*;

  logic [CFG_AW-2:0]        sel;
  logic                     is_map;
  logic                     we_ctl, we_rpk, we_vm;
  logic [ADDR_W-1:0]        ctl_q, rpk_q;
  logic [ADDR_W-VM_LSB-1:0] vm_hi_q;
  logic [MAP_IDX_W-1:0]     midx;

  assign is_map = addr_i[CFG_AW-1];
  assign sel    = addr_i[CFG_AW-2:0];
  assign midx   = addr_i[MAP_IDX_W-1:0];
  assign we_ctl = we_i && !is_map && (sel == (CFG_AW-1)'(SEL_CTL));
  assign we_rpk = we_i && !is_map && (sel == (CFG_AW-1)'(SEL_RPK));
  assign we_vm  = we_i && !is_map && (sel == (CFG_AW-1)'(SEL_VM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      rpk_q   <= RPK_BASE_RST;
      vm_hi_q <= VM_BASE_RST[ADDR_W-1:VM_LSB];
    end else begin
      if (we_ctl) ctl_q   <= wdata_i;
      if (we_rpk) rpk_q   <= wdata_i;
      if (we_vm)  vm_hi_q <= wdata_i[ADDR_W-1:VM_LSB];
    end
  end

  for (genvar g = 0; g < MAP_DEPTH; g++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      map_o[g] <= '0;
      else if (we_i && is_map && midx == MAP_IDX_W'(g)) map_o[g] <= wdata_i;
    end
  end

  assign ctl_base_o = ctl_q;
  assign rpk_base_o = rpk_q;
  assign vm_base_o  = {vm_hi_q, {VM_LSB{1'b0}}};

  always_comb begin
    rdata_o = '0;
    if (is_map)                           rdata_o = map_o[midx];
    else if (sel == (CFG_AW-1)'(SEL_CTL)) rdata_o = ctl_q;
    else if (sel == (CFG_AW-1)'(SEL_RPK)) rdata_o = rpk_q;
    else if (sel == (CFG_AW-1)'(SEL_VM))  rdata_o = vm_base_o;
  end
endmodule

// File: rtl/mem_region_xlat.sv
module mem_region_xlat #(
  parameter int                ADDR_W       = 32,
  parameter int                BUF_LOG2     = 11,
  parameter int                MAP_DEPTH    = 16,
  parameter int                VM_LSB       = 17,
  parameter logic [ADDR_W-1:0] RPK_BASE_RST = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] VM_BASE_RST  = 32'h0040_0000,
  localparam int MAP_IDX_W = $clog2(MAP_DEPTH),
  localparam int CFG_AW    = ((MAP_IDX_W > 2) ? MAP_IDX_W : 2) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] cfg_rdata_o,
  input  logic              cpu_valid_i,
  output logic              cpu_ready_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_cbus_valid_o,
  input  logic              cpu_cbus_ready_i,
  output logic [ADDR_W-1:0] cpu_cbus_addr_o,
  output logic              cpu_pbus_valid_o,
  input  logic              cpu_pbus_ready_i,
  output logic [ADDR_W-1:0] cpu_pbus_addr_o,
  input  logic              cbus_valid_i,
  output logic              cbus_ready_o,
  input  logic [ADDR_W-1:0] cbus_addr_i,
  output logic              cmem_valid_o,
  input  logic              cmem_ready_i,
  output logic [ADDR_W-1:0] cmem_addr_o,
  input  logic              pbus_valid_i,
  output logic              pbus_ready_o,
  input  logic [ADDR_W-1:0] pbus_addr_i,
  output logic              pmem_valid_o,
  input  logic              pmem_ready_i,
  output logic [ADDR_W-1:0] pmem_addr_o,
  output logic              pmem_err_o
);
  localparam int HI_LSB = BUF_LOG2 + MAP_IDX_W;

  logic [ADDR_W-1:0]                ctl_base, rpk_base, vm_base;
  logic [MAP_DEPTH-1:0][ADDR_W-1:0] map;

  xlat_cfg #(
    .ADDR_W(ADDR_W), .MAP_DEPTH(MAP_DEPTH), .VM_LSB(VM_LSB),
    .RPK_BASE_RST(RPK_BASE_RST), .VM_BASE_RST(VM_BASE_RST)
  ) cfg_i (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .ctl_base_o(ctl_base), .rpk_base_o(rpk_base), .vm_base_o(vm_base), .map_o(map)
  );

  // processor routing
  logic to_ctl, rt_c_rdy, rt_p_rdy;
  assign to_ctl      = cpu_addr_i < rpk_base;
  assign cpu_ready_o = to_ctl ? rt_c_rdy : rt_p_rdy;

  xlat_slice #(.W(ADDR_W)) rt_c_i (
    .clk_i, .rst_ni,
    .in_valid_i(cpu_valid_i && to_ctl), .in_ready_o(rt_c_rdy), .in_data_i(cpu_addr_i),
    .out_valid_o(cpu_cbus_valid_o), .out_ready_i(cpu_cbus_ready_i), .out_data_o(cpu_cbus_addr_o)
  );
  xlat_slice #(.W(ADDR_W)) rt_p_i (
    .clk_i, .rst_ni,
    .in_valid_i(cpu_valid_i && !to_ctl), .in_ready_o(rt_p_rdy), .in_data_i(cpu_addr_i),
    .out_valid_o(cpu_pbus_valid_o), .out_ready_i(cpu_pbus_ready_i), .out_data_o(cpu_pbus_addr_o)
  );

  // control rebase
  xlat_slice #(.W(ADDR_W)) cm_i (
    .clk_i, .rst_ni,
    .in_valid_i(cbus_valid_i), .in_ready_o(cbus_ready_o), .in_data_i(cbus_addr_i - ctl_base),
    .out_valid_o(cmem_valid_o), .out_ready_i(cmem_ready_i), .out_data_o(cmem_addr_o)
  );

  // packet: real or virtual
  logic                 is_virt, oor;
  logic [ADDR_W-1:0]    voff, paddr;
  logic [MAP_IDX_W-1:0] vidx;
  logic                 err_q;

  assign is_virt = pbus_addr_i >= vm_base;
  assign voff    = pbus_addr_i - vm_base;
  assign vidx    = voff[HI_LSB-1:BUF_LOG2];
  assign oor     = is_virt && (|voff[ADDR_W-1:HI_LSB]);
  assign paddr   = is_virt ? map[vidx] + ADDR_W'(voff[BUF_LOG2-1:0])
                           : pbus_addr_i - rpk_base;

  xlat_slice #(.W(ADDR_W)) pm_i (
    .clk_i, .rst_ni,
    .in_valid_i(pbus_valid_i && !oor), .in_ready_o(pbus_ready_o), .in_data_i(paddr),
    .out_valid_o(pmem_valid_o), .out_ready_i(pmem_ready_i), .out_data_o(pmem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= pbus_valid_i && pbus_ready_o && oor;
  end
  assign pmem_err_o = err_q;
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_valid_i,
  input logic              cpu_ready_o,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [ADDR_W-1:0] rpk_base,
  input logic              cpu_cbus_valid_o,
  input logic              cpu_pbus_valid_o,
  input logic              cmem_valid_o,
  input logic              cmem_ready_i,
  input logic [ADDR_W-1:0] cmem_addr_o,
  input logic              pbus_ready_o,
  input logic              pmem_valid_o,
  input logic              pmem_ready_i,
  input logic [ADDR_W-1:0] pmem_addr_o,
  input logic              pmem_err_o
);
  AST_CPU_TO_CBUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_i && cpu_ready_o && (cpu_addr_i < rpk_base) |=> cpu_cbus_valid_o); // R2
  AST_CPU_TO_PBUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_i && cpu_ready_o && (cpu_addr_i >= rpk_base) |=> cpu_pbus_valid_o); // R2
  AST_ERR_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmem_err_o |-> !pmem_valid_o); // R6
  AST_CMEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmem_valid_o && !cmem_ready_i |=> cmem_valid_o && $stable(cmem_addr_o)); // R8
  AST_PMEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmem_valid_o && !pmem_ready_i |=> pmem_valid_o && $stable(pmem_addr_o)); // R8
  AST_PBUS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmem_valid_o && !pmem_ready_i |-> !pbus_ready_o); // R8
endmodule

bind mem_region_xlat xlat_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cpu_valid_i(cpu_valid_i), .cpu_ready_o(cpu_ready_o), .cpu_addr_i(cpu_addr_i),
  .rpk_base(rpk_base),
  .cpu_cbus_valid_o(cpu_cbus_valid_o), .cpu_pbus_valid_o(cpu_pbus_valid_o),
  .cmem_valid_o(cmem_valid_o), .cmem_ready_i(cmem_ready_i), .cmem_addr_o(cmem_addr_o),
  .pbus_ready_o(pbus_ready_o),
  .pmem_valid_o(pmem_valid_o), .pmem_ready_i(pmem_ready_i), .pmem_addr_o(pmem_addr_o),
  .pmem_err_o(pmem_err_o)
);

// File: tb/mem_region_xlat_tb_top.sv
`timescale 1ns/1ps
module mem_region_xlat_tb_top;
  localparam int AW = 32;
  localparam int BL = 6;
  localparam int MD = 4;
  localparam int CAW = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic           cfg_we = 0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [AW-1:0]  cfg_wdata = '0, cfg_rdata;
  logic cpu_v = 0, cpu_r; logic [AW-1:0] cpu_a = '0;
  logic cc_v, cc_r = 1, cp_v, cp_r = 1; logic [AW-1:0] cc_a, cp_a;
  logic cb_v = 0, cb_r; logic [AW-1:0] cb_a = '0;
  logic cm_v, cm_r = 1; logic [AW-1:0] cm_a;
  logic pb_v = 0, pb_r; logic [AW-1:0] pb_a = '0;
  logic pm_v, pm_r = 1, pm_e; logic [AW-1:0] pm_a;

  mem_region_xlat #(.ADDR_W(AW), .BUF_LOG2(BL), .MAP_DEPTH(MD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .cpu_valid_i(cpu_v), .cpu_ready_o(cpu_r), .cpu_addr_i(cpu_a),
    .cpu_cbus_valid_o(cc_v), .cpu_cbus_ready_i(cc_r), .cpu_cbus_addr_o(cc_a),
    .cpu_pbus_valid_o(cp_v), .cpu_pbus_ready_i(cp_r), .cpu_pbus_addr_o(cp_a),
    .cbus_valid_i(cb_v), .cbus_ready_o(cb_r), .cbus_addr_i(cb_a),
    .cmem_valid_o(cm_v), .cmem_ready_i(cm_r), .cmem_addr_o(cm_a),
    .pbus_valid_i(pb_v), .pbus_ready_o(pb_r), .pbus_addr_i(pb_a),
    .pmem_valid_o(pm_v), .pmem_ready_i(pm_r), .pmem_addr_o(pm_a), .pmem_err_o(pm_e)
  );

  int checks = 0, errors = 0;
  logic [AW-1:0] ctl_b, rpk_b, vm_b;
  logic [AW-1:0] mapv [MD];

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [CAW-1:0] a, input logic [AW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [CAW-1:0] a, input logic [AW-1:0] exp, input string req);
    @(negedge clk); cfg_addr = a; #1;
    chk(cfg_rdata === exp, req, cfg_rdata, exp);
  endtask

  initial begin : wdog
    #(5ns * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] off, exp;
    #1;
    // R1 reset state
    chk(!cc_v && !cp_v && !cm_v && !pm_v && !pm_e, "R1", {cc_v,cp_v,cm_v,pm_v,pm_e}, 0);
    #10 rst_n = 1;
    rd(3'b000, 32'h0, "R1"); rd(3'b001, 32'h0010_0000, "R1");
    rd(3'b010, 32'h0040_0000, "R1"); rd(3'b100, 32'h0, "R1");
    // R7 low bits discarded
    wr(3'b010, 32'h0042_5A5A); rd(3'b010, 32'h0042_0000, "R7");
    wr(3'b010, 32'h0061_FFFF); rd(3'b010, 32'h0060_0000, "R7");
    // R9 map and unused code
    ctl_b = 32'h0000_1000; rpk_b = 32'h0010_0000; vm_b = 32'h0060_0000;
    wr(3'b000, ctl_b); wr(3'b001, rpk_b);
    wr(3'b011, 32'hDEAD_BEEF); rd(3'b011, 32'h0, "R9");
    rd(3'b000, ctl_b, "R9"); rd(3'b001, rpk_b, "R9");
    for (int i = 0; i < MD; i++) begin
      mapv[i] = 32'h8000_0000 + 32'(i) * 32'h0001_0040 + 32'(i*3);
      wr(3'(4 + i), mapv[i]);
    end
    for (int i = 0; i < MD; i++) rd(3'(4 + i), mapv[i], "R9");

    // R2 routing sweep across the real-packet base
    for (int k = -40; k <= 40; k++) begin
      cpu_a = rpk_b + 32'(k * 7);
      @(negedge clk); cpu_v = 1;
      @(negedge clk); cpu_v = 0;
      if (cpu_a < rpk_b) chk(cc_v && !cp_v && cc_a == cpu_a, "R2", cc_a, cpu_a);
      else               chk(cp_v && !cc_v && cp_a == cpu_a, "R2", cp_a, cpu_a);
    end

    // R3 control rebase sweep
    for (int k = 0; k < 64; k++) begin
      cb_a = 32'(k) * 32'h0000_0111 + 32'h0000_0F80;
      @(negedge clk); cb_v = 1;
      @(negedge clk); cb_v = 0;
      exp = cb_a - ctl_b;
      chk(cm_v && cm_a == exp, "R3", cm_a, exp);
    end

    // R4/R5/R6 packet sweep across virtual base and map end
    for (int k = -300; k < MD * 64 + 200; k += 3) begin
      pb_a = vm_b + 32'(k);
      @(negedge clk); pb_v = 1;
      @(negedge clk); pb_v = 0;
      if (pb_a < vm_b) begin
        exp = pb_a - rpk_b;
        chk(pm_v && !pm_e && pm_a == exp, "R4", pm_a, exp);
      end else begin
        off = pb_a - vm_b;
        if ((off >> BL) >= MD) chk(!pm_v && pm_e, "R6", {pm_v, pm_e}, 32'h1);
        else begin
          exp = mapv[off >> BL] + (off & 32'h3F);
          chk(pm_v && !pm_e && pm_a == exp, "R5", pm_a, exp);
        end
      end
    end
    // R6 pulse lasts one cycle
    @(negedge clk); chk(!pm_e, "R6", pm_e, 0);

    // R8 back-pressure hold
    pm_r = 0;
    pb_a = vm_b + 32'h45;
    @(negedge clk); pb_v = 1;
    @(negedge clk);
    exp = mapv[1] + 32'h05;
    chk(pm_v && pm_a == exp, "R8", pm_a, exp);
    pb_a = vm_b - 32'h10;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!pb_r && pm_v && pm_a == exp, "R8", pm_a, exp);
    end
    pm_r = 1;
    @(negedge clk); pb_v = 0;
    exp = vm_b - 32'h10 - rpk_b;
    chk(pm_v && pm_a == exp, "R8", pm_a, exp);
    @(negedge clk);
    chk(!pm_v, "R8", pm_v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule